// File: doc/BRIEF.md
# Link Receiver-Detect Sequencer

This block runs the transmitter-side test that decides whether a far-end receiver is attached to a serial lane. A rising edge on the request input starts the test, but only when both the transmit and the receive power-state inputs carry the low-power code in which detection is allowed. The block then drives the line to a mid-supply level for a fixed number of cycles and releases it. It waits for a programmable settling interval and samples a threshold comparator. The outcome appears on a 3-bit status bus, together with a one-cycle completion strobe.

The analog front end sits outside the block. It is represented by a single line-drive output and a single comparator input. If a request arrives in any other power state, the line is left alone and the block answers at once with a "not detected" result. The settling interval is captured from a configuration input when the test begins.

Top module: `rxdet_seq`

## Requirements
- R1: A synchronous active-high reset, applied at any time including mid-test, leaves `line_drive_o`, `det_done_o` and `det_status_o` all low, and the block idle.
- R2: A test starts on the first clock edge that sees `det_req_i` high after it was low, if both `tx_pwr_i` and `rx_pwr_i` equal 2'b10. Power codes are 00 normal, 01 fast-recovery low power, 10 detect-capable low power and 11 deepest sleep. `line_drive_o` then goes high after that edge and stays high for exactly DRIVE_LEN cycles.
- R3: After the line is released, the block waits W cycles, where W is the captured `wait_cfg_i`. `det_done_o` is high in cycle DRIVE_LEN+W+1, counting the cycle after the starting edge as cycle 1.
- R4: A captured wait value of zero behaves exactly like a value of one.
- R5: In the completion cycle `det_status_o` is 3'b011 if `cmp_i` was high at the sampling edge, and 3'b000 if it was low. In every other cycle `det_status_o` is 3'b000.
- R6: `det_done_o` is high for exactly one cycle per test.
- R7: A request edge seen while either power input differs from 2'b10 never raises `line_drive_o`. `det_done_o` is high in the very next cycle, with status 3'b000.
- R8: Request edges during a running test are ignored. A request held high after completion does not start a new test; the input has to fall and rise again.
- R9: Changes to `wait_cfg_i` after the starting edge do not alter the running test's timing.
- R10: Only the value of `cmp_i` at the edge that ends the wait matters. Its value in earlier cycles has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit user clock |
| rst | input | 1 | Synchronous active-high reset |
| det_req_i | input | 1 | Detect request, acted on at its rising edge |
| tx_pwr_i | input | 2 | Transmit power-state code |
| rx_pwr_i | input | 2 | Receive power-state code |
| wait_cfg_i | input | WAIT_W (16) | Settling interval in cycles, captured at start |
| cmp_i | input | 1 | Threshold comparator result from the front end |
| line_drive_o | output | 1 | High while the line is held at mid level |
| det_done_o | output | 1 | One-cycle completion strobe |
| det_status_o | output | 3 | Result code, valid with the strobe |

## Verification
The bench builds the block with DRIVE_LEN = 3, so the drive phase is long enough to be told apart from the settling wait. WAIT_W keeps its default of 16 bits. With that width the bench can load a zero interval, a one-cycle interval and a wait of a thousand cycles. The bench can also move the comparator so that its level at the sampling edge differs from its level in every earlier cycle.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

    localparam logic [1:0] PWR_DETECT  = 2'b10;
    localparam logic [2:0] STAT_FOUND  = 3'b011;
    localparam logic [2:0] STAT_NONE   = 3'b000;

    typedef struct packed {
        seq_st_e    st;
        logic       drive;
        logic       done;
        logic [2:0] status;
    } seq_regs_t;

endpackage

// File: rtl/rxdet_rise.sv
module rxdet_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;

    // A held level produces at most one rise indication
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R8
endmodule

// File: rtl/rxdet_timer.sv
module rxdet_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         last_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (val_i == '0) ? ONE : val_i;
        end else if (dec_i && cnt_q > ONE) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= ONE;
        else     cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == ONE);

    AST_ZERO_LOADS_ONE: assert property (@(posedge clk) disable iff (rst)
        (load_i && val_i == '0) |=> last_o); // R4
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !dec_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq #(
    parameter int DRIVE_LEN = 2,
    parameter int WAIT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_req_i,
    input  logic [1:0]        tx_pwr_i,
    input  logic [1:0]        rx_pwr_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    input  logic              cmp_i,
    output logic              line_drive_o,
    output logic              det_done_o,
    output logic [2:0]        det_status_o
);
    import rxdet_pkg::*;

    localparam int DRV_W = $clog2(DRIVE_LEN + 1);
    localparam logic [DRV_W-1:0] DRV_LOAD = DRV_W'(DRIVE_LEN);

    seq_regs_t r_d, r_q;
    logic req_rise;
    logic drv_load, drv_dec, drv_last;
    logic wt_load, wt_dec, wt_last;
    logic pwr_ok;

    rxdet_rise u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (det_req_i),
        .rise_o (req_rise)
    );

    rxdet_timer #(.W(DRV_W)) u_drv_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (drv_load),
        .val_i  (DRV_LOAD),
        .dec_i  (drv_dec),
        .last_o (drv_last)
    );

    rxdet_timer #(.W(WAIT_W)) u_wait_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (wt_load),
        .val_i  (wait_cfg_i),
        .dec_i  (wt_dec),
        .last_o (wt_last)
    );

    assign pwr_ok = (tx_pwr_i == PWR_DETECT) && (rx_pwr_i == PWR_DETECT);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.status = STAT_NONE;
        drv_load   = 1'b0;
        drv_dec    = 1'b0;
        wt_load    = 1'b0;
        wt_dec     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_rise) begin
                    if (pwr_ok) begin
                        r_d.st    = ST_DRIVE;
                        r_d.drive = 1'b1;
                        drv_load  = 1'b1;
                        wt_load   = 1'b1;
                    end else begin
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_DRIVE: begin
                if (drv_last) begin
                    r_d.st    = ST_WAIT;
                    r_d.drive = 1'b0;
                end else begin
                    drv_dec   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (wt_last) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.status = cmp_i ? STAT_FOUND : STAT_NONE;
                end else begin
                    wt_dec     = 1'b1;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.drive = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st     <= ST_IDLE;
            r_q.drive  <= 1'b0;
            r_q.done   <= 1'b0;
            r_q.status <= STAT_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_drive_o = r_q.drive;
    assign det_done_o   = r_q.done;
    assign det_status_o = r_q.status;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        det_done_o |=> !det_done_o); // R6
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !det_done_o |-> det_status_o == STAT_NONE); // R5
    AST_FOUND_FROM_CMP: assert property (@(posedge clk) disable iff (rst)
        (det_status_o == STAT_FOUND) |-> $past(cmp_i)); // R5
    AST_DRIVE_NEEDS_P1: assert property (@(posedge clk) disable iff (rst)
        $rose(line_drive_o) |-> ($past(tx_pwr_i) == PWR_DETECT && $past(rx_pwr_i) == PWR_DETECT)); // R7
    AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        det_done_o |-> !line_drive_o); // R3
    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_WAIT) |-> !line_drive_o); // R3
endmodule

// File: tb/rxdet_seq_tb.sv
module rxdet_seq_tb_top;
    localparam int DL = 3;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          det_req = 1'b0;
    logic [1:0]    tx_pwr = 2'b10;
    logic [1:0]    rx_pwr = 2'b10;
    logic [WW-1:0] wait_cfg = '0;
    logic          cmp = 1'b0;
    logic          line_drive, det_done;
    logic [2:0]    det_status;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rxdet_seq #(.DRIVE_LEN(DL), .WAIT_W(WW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .det_req_i    (det_req),
        .tx_pwr_i     (tx_pwr),
        .rx_pwr_i     (rx_pwr),
        .wait_cfg_i   (wait_cfg),
        .cmp_i        (cmp),
        .line_drive_o (line_drive),
        .det_done_o   (det_done),
        .det_status_o (det_status)
    );

    // fields: tx[20:19] rx[18:17] cfg[16:1] cmp[0]
    localparam logic [20:0] VEC [10] = '{
        {2'b10, 2'b10, 16'd5,    1'b1},
        {2'b10, 2'b10, 16'd5,    1'b0},
        {2'b10, 2'b10, 16'd0,    1'b1},
        {2'b10, 2'b10, 16'd1,    1'b1},
        {2'b10, 2'b10, 16'd1000, 1'b0},
        {2'b00, 2'b00, 16'd7,    1'b1},
        {2'b01, 2'b01, 16'd3,    1'b1},
        {2'b11, 2'b11, 16'd3,    1'b1},
        {2'b10, 2'b00, 16'd4,    1'b1},
        {2'b00, 2'b10, 16'd4,    1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs one test; cmp takes cmp_samp only for the sampling edge.
    task automatic run_test(input logic [1:0] tx, input logic [1:0] rx,
                            input logic [WW-1:0] cfg, input logic cmp_other,
                            input logic cmp_samp, input int cfg_alt);
        bit p1;
        int w, exp_lat, exp_drv, exp_st, n, drv_cnt, quiet_bad;
        p1      = (tx == 2'b10) && (rx == 2'b10);
        w       = (cfg == 0) ? 1 : int'(cfg);
        exp_lat = p1 ? DL + w + 1 : 1;
        exp_drv = p1 ? DL : 0;
        exp_st  = (p1 && cmp_samp) ? 3 : 0;
        n = 0; drv_cnt = 0; quiet_bad = 0;
        @(negedge clk);
        tx_pwr = tx; rx_pwr = rx; wait_cfg = cfg;
        cmp = (exp_lat == 1) ? cmp_samp : cmp_other;
        det_req = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (cfg_alt >= 0 && n == 1) wait_cfg = WW'(cfg_alt);
            if (line_drive) drv_cnt++;
            if (det_done) break;
            if (det_status != 3'b000) quiet_bad++;
            cmp = (n == exp_lat - 1) ? cmp_samp : cmp_other;
            if (n > exp_lat + 5) break;
        end
        chk(n == exp_lat, "R3/R7 latency", n, exp_lat);
        chk(drv_cnt == exp_drv, "R2/R7 drive cycles", drv_cnt, exp_drv);
        chk(int'(det_status) == exp_st, "R5/R10 status", int'(det_status), exp_st);
        chk(quiet_bad == 0, "R5 status quiet", quiet_bad, 0);
        @(negedge clk);
        chk(!det_done, "R6 single pulse", int'(det_done), 0);
        det_req = 1'b0;
        cmp = 1'b0;
        idle_cycles(2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int drv_seen, done_seen, n;
        idle_cycles(3);
        // R1 reset state
        chk(!line_drive && !det_done && det_status == 3'b000, "R1 reset outputs",
            {line_drive, det_done, det_status}, 0);
        rst = 1'b0;
        idle_cycles(2);

        // table walk
        foreach (VEC[i]) begin
            run_test(VEC[i][20:19], VEC[i][18:17], VEC[i][16:1], VEC[i][0], VEC[i][0], -1);
        end

        // R4: zero and one give the same latency
        run_test(2'b10, 2'b10, 16'd0, 1'b0, 1'b1, -1);
        run_test(2'b10, 2'b10, 16'd1, 1'b0, 1'b1, -1);

        // R10: comparator differs from sampled value on every other cycle
        run_test(2'b10, 2'b10, 16'd6, 1'b0, 1'b1, -1);
        run_test(2'b10, 2'b10, 16'd6, 1'b1, 1'b0, -1);

        // R9: configuration changed right after start
        run_test(2'b10, 2'b10, 16'd8, 1'b1, 1'b1, 40);
        run_test(2'b10, 2'b10, 16'd20, 1'b1, 1'b1, 0);

        // R8: held request does not retrigger
        @(negedge clk);
        tx_pwr = 2'b10; rx_pwr = 2'b10; wait_cfg = 16'd2; det_req = 1'b1;
        done_seen = 0;
        for (int i = 0; i < DL + 3; i++) begin
            @(negedge clk);
            if (det_done) done_seen++;
        end
        drv_seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (line_drive) drv_seen++;
            if (det_done) done_seen++;
        end
        chk(done_seen == 1 && drv_seen == 0, "R8 held request", done_seen * 100 + drv_seen, 100);
        det_req = 1'b0;
        idle_cycles(2);

        // R8: request re-edge during running test ignored
        @(negedge clk);
        wait_cfg = 16'd10; det_req = 1'b1;
        n = 0; done_seen = 0;
        for (int i = 0; i < DL + 30; i++) begin
            @(negedge clk);
            if (i == 1) det_req = 1'b0;
            if (i == 3) det_req = 1'b1;
            if (det_done) begin
                done_seen++;
                if (done_seen == 1) n = i + 1;
            end
        end
        chk(n == DL + 11, "R8 re-edge latency", n, DL + 11);
        chk(done_seen == 1, "R8 re-edge single completion", done_seen, 1);
        det_req = 1'b0;
        idle_cycles(2);

        // R1: reset in the middle of a test
        @(negedge clk);
        wait_cfg = 16'd50; det_req = 1'b1;
        idle_cycles(2);
        chk(line_drive, "R2 drive active before reset", int'(line_drive), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!line_drive && !det_done && det_status == 3'b000, "R1 mid-test reset",
            {line_drive, det_done, det_status}, 0);
        det_req = 1'b0;
        rst = 1'b0;
        done_seen = 0; drv_seen = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (det_done) done_seen++;
            if (line_drive) drv_seen++;
        end
        chk(done_seen == 0 && drv_seen == 0, "R1 idle after reset", done_seen * 100 + drv_seen, 0);

        // fresh test after reset still works
        run_test(2'b10, 2'b10, 16'd3, 1'b1, 1'b1, -1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule